// File: doc/BRIEF.md
# Chained Buffer Transfer Address Controller

This block produces the main-storage addresses for the character transfers of a single communication line. The line's buffer is described by two control words. The current word holds the address of the next character. The terminal word holds the last address of the buffer together with three control bits: step direction, half-word select and chaining. Each accepted transfer request yields one memory address and one half select. The current address then moves one step up or down.

When a transfer lands on the terminal address, the buffer is finished. If chaining is enabled, the block reads the next descriptor pair from storage just past the terminal address and carries on without software. If chaining is disabled, it clears the terminal word, which disarms the line. A request on a disarmed line is dropped quietly, and the shared channel keeps running. Every end of buffer raises a one-cycle termination event so that a status logger can record it. A separate arm request loads a first descriptor pair from any pointer.

Top module: `cbt_addr_ctrl`

## Requirements
- R1: After reset, both control words are zero, so the line is disarmed. `req_ready` is 1, and `mem_valid`, `term_valid` and `rd_req` are 0.
- R2: A request accepted on an armed line (`xfer_req` and `req_ready` both 1 at a clock edge) gives a one-cycle `mem_valid` pulse in the next cycle. That pulse carries `mem_addr` equal to the current address and `mem_half` equal to terminal-word bit ADDR_W+1 (0 = lower half, 1 = upper half).
- R3: After a transfer that does not end the buffer, the current address steps by one, modulo 2^ADDR_W. It steps up when terminal-word bit ADDR_W is 0 and down when that bit is 1.
- R4: A transfer whose address equals the terminal address (terminal-word bits ADDR_W-1:0) ends the buffer. `term_valid` then pulses in the same cycle as that transfer's `mem_valid`. `term_addr` carries the terminal address, and `term_chained` carries terminal-word bit ADDR_W+2.
- R5: When a buffer ends with bit ADDR_W+2 set to 1, the block reads the word at terminal address + 1 as the new terminal word, then the word at terminal address + 2 as the new current address. Both additions wrap. Transfers then resume from the new current address.
- R6: When a buffer ends with bit ADDR_W+2 set to 0, the terminal word becomes zero. Any later request is accepted but dropped: there is no `mem_valid`, no `term_valid` and no read.
- R7: While a descriptor read is in progress, `req_ready` is 0. A request held during that time is served once the read is done and is not lost.
- R8: `arm_valid` while the block is idle loads the word at `arm_ptr` as the terminal word and the word at `arm_ptr` + 1 as the current address. This replaces any live buffer. While `arm_valid` is 1, `req_ready` is 0.
- R9: Each descriptor read is one single-cycle `rd_req` pulse. A fetch makes exactly two reads, terminal word first. A second read is not issued until `rd_valid` has answered the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| arm_valid | input | 1 | Load a descriptor pair from `arm_ptr` |
| arm_ptr | input | ADDR_W | Address of the first descriptor word |
| xfer_req | input | 1 | Character transfer request |
| req_ready | output | 1 | Block can accept a transfer request |
| mem_valid | output | 1 | Transfer address is valid (one cycle) |
| mem_addr | output | ADDR_W | Storage address of the transfer |
| mem_half | output | 1 | Half-word select of the transfer |
| term_valid | output | 1 | End-of-buffer event (one cycle) |
| term_chained | output | 1 | The finished buffer chained to a new one |
| term_addr | output | ADDR_W | Terminal address of the finished buffer |
| rd_req | output | 1 | Descriptor read request (one cycle) |
| rd_addr | output | ADDR_W | Descriptor read address |
| rd_valid | input | 1 | Descriptor read data is valid |
| rd_data | input | ADDR_W+3 | Descriptor read data |

## Verification
The bench builds the block with ADDR_W = 8 and a memory model that answers each read two cycles late. The small address space brings wrap-around within reach. One buffer climbs from 0xFE through 0x00 to 0x01. Another falls from 0x01 through 0xFF to 0xFE, and its follow-on descriptor sits at 0xFF and 0x00, so the descriptor read address itself wraps. The added read latency makes the stall window long enough that a request held across a chain fetch shows whether it is kept or lost.

// File: rtl/cbt_pkg.sv
package cbt_pkg;

  // Descriptor fetch sequencer states.
  typedef enum logic [2:0] {
    FS_IDLE,
    FS_TERM_REQ,
    FS_TERM_WAIT,
    FS_CUR_REQ,
    FS_CUR_WAIT
  } fetch_st_e;

endpackage

// File: rtl/cbt_step.sv
module cbt_step #(
  parameter int ADDR_W = 15
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              down_i,
  output logic [ADDR_W-1:0] addr_o
);

  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  // Wrapping single step; the direction comes from the terminal word.
  always_comb begin
    if (down_i) addr_o = addr_i - ONE;
    else        addr_o = addr_i + ONE;
  end

endmodule

// File: rtl/cbt_end_detect.sv
module cbt_end_detect #(
  parameter int ADDR_W = 15,
  parameter int WORD_W = ADDR_W + 3
) (
  input  logic [WORD_W-1:0] term_word_i,
  input  logic [ADDR_W-1:0] cur_addr_i,
  output logic              armed_o,
  output logic              at_end_o,
  output logic              chain_o,
  output logic              down_o,
  output logic              upper_o,
  output logic [ADDR_W-1:0] term_addr_o
);

  localparam int DIR_BIT   = ADDR_W;
  localparam int HALF_BIT  = ADDR_W + 1;
  localparam int CHAIN_BIT = ADDR_W + 2;

  always_comb begin
    term_addr_o = term_word_i[ADDR_W-1:0];
    down_o      = term_word_i[DIR_BIT];
    upper_o     = term_word_i[HALF_BIT];
    chain_o     = term_word_i[CHAIN_BIT];
    // An all-zero terminal word marks a disarmed line.
    armed_o     = |term_word_i;
    at_end_o    = (cur_addr_i == term_word_i[ADDR_W-1:0]);
  end

endmodule

// File: rtl/cbt_rst_sync.sv
module cbt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/cbt_desc_fetch.sv
module cbt_desc_fetch
  import cbt_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int WORD_W = ADDR_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_valid_i,
  output logic              term_load_o,
  output logic              cur_load_o,
  output logic              busy_o
);

  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  fetch_st_e         state_q, state_d;
  logic [ADDR_W-1:0] base_q;
  logic              base_en;

  // Next-state process
  always_comb begin
    state_d = state_q;
    base_en = 1'b0;
    case (state_q)
      FS_IDLE: begin
        if (start_i) begin
          state_d = FS_TERM_REQ;
          base_en = 1'b1;
        end
      end
      FS_TERM_REQ:  state_d = FS_TERM_WAIT;
      FS_TERM_WAIT: if (rd_valid_i) state_d = FS_CUR_REQ;
      FS_CUR_REQ:   state_d = FS_CUR_WAIT;
      FS_CUR_WAIT:  if (rd_valid_i) state_d = FS_IDLE;
      default:      state_d = FS_IDLE;
    endcase
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FS_IDLE;
      base_q  <= '0;
    end else begin
      state_q <= state_d;
      if (base_en) base_q <= base_i;
    end
  end

  always_comb begin
    rd_req_o    = (state_q == FS_TERM_REQ) || (state_q == FS_CUR_REQ);
    rd_addr_o   = (state_q == FS_CUR_REQ) ? base_q + ONE : base_q;
    term_load_o = (state_q == FS_TERM_WAIT) && rd_valid_i;
    cur_load_o  = (state_q == FS_CUR_WAIT) && rd_valid_i;
    busy_o      = (state_q != FS_IDLE);
  end

endmodule

// File: rtl/cbt_addr_ctrl.sv
module cbt_addr_ctrl #(
  parameter int ADDR_W = 15
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                arm_valid,
  input  logic [ADDR_W-1:0]   arm_ptr,
  input  logic                xfer_req,
  output logic                req_ready,
  output logic                mem_valid,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic                mem_half,
  output logic                term_valid,
  output logic                term_chained,
  output logic [ADDR_W-1:0]   term_addr,
  output logic                rd_req,
  output logic [ADDR_W-1:0]   rd_addr,
  input  logic                rd_valid,
  input  logic [ADDR_W+2:0]   rd_data
);

  localparam int WORD_W = ADDR_W + 3;
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic              rst_int_n;
  logic [WORD_W-1:0] term_q, term_d;
  logic [ADDR_W-1:0] cur_q, cur_d;
  logic              term_en, cur_en;

  logic              armed, at_end, chain, down, upper;
  logic [ADDR_W-1:0] t_addr, step_addr, fetch_base;
  logic              busy, term_load, cur_load;
  logic              accept, do_xfer, arm_go, chain_go, end_go;

  cbt_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_int_n)
  );

  cbt_end_detect #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) end_det_i (
    .term_word_i (term_q),
    .cur_addr_i  (cur_q),
    .armed_o     (armed),
    .at_end_o    (at_end),
    .chain_o     (chain),
    .down_o      (down),
    .upper_o     (upper),
    .term_addr_o (t_addr)
  );

  cbt_step #(.ADDR_W(ADDR_W)) step_i (
    .addr_i (cur_q),
    .down_i (down),
    .addr_o (step_addr)
  );

  cbt_desc_fetch #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) fetch_i (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .start_i     (arm_go || chain_go),
    .base_i      (fetch_base),
    .rd_req_o    (rd_req),
    .rd_addr_o   (rd_addr),
    .rd_valid_i  (rd_valid),
    .term_load_o (term_load),
    .cur_load_o  (cur_load),
    .busy_o      (busy)
  );

  // Handshake and event decode
  always_comb begin
    req_ready  = !busy && !arm_valid;
    accept     = xfer_req && req_ready;
    do_xfer    = accept && armed;
    end_go     = do_xfer && at_end;
    chain_go   = end_go && chain;
    arm_go     = arm_valid && !busy;
    fetch_base = arm_go ? arm_ptr : t_addr + ONE;
  end

  // Control word next values
  always_comb begin
    term_en = term_load || (end_go && !chain);
    term_d  = term_load ? rd_data : '0;
    cur_en  = cur_load || (do_xfer && !at_end);
    cur_d   = cur_load ? rd_data[ADDR_W-1:0] : step_addr;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      term_q <= '0;
      cur_q  <= '0;
    end else begin
      if (term_en) term_q <= term_d;
      if (cur_en)  cur_q  <= cur_d;
    end
  end

  // Output registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      mem_valid    <= 1'b0;
      mem_addr     <= '0;
      mem_half     <= 1'b0;
      term_valid   <= 1'b0;
      term_chained <= 1'b0;
      term_addr    <= '0;
    end else begin
      mem_valid  <= do_xfer;
      term_valid <= end_go;
      if (do_xfer) begin
        mem_addr <= cur_q;
        mem_half <= upper;
      end
      if (end_go) begin
        term_chained <= chain;
        term_addr    <= t_addr;
      end
    end
  end

endmodule

// File: rtl/cbt_addr_ctrl_chk.sv
module cbt_addr_ctrl_chk #(
  parameter int ADDR_W = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              xfer_req,
  input logic              req_ready,
  input logic              mem_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              term_valid,
  input logic              term_chained,
  input logic              rd_req,
  input logic [ADDR_W+2:0] term_word,
  input logic [ADDR_W-1:0] cur_addr
);

  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  assert_xfer_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> $past(xfer_req && req_ready));

  assert_step_dir_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !term_valid) |->
      (cur_addr == (term_word[ADDR_W] ? mem_addr - ONE : mem_addr + ONE)));

  assert_end_with_xfer_R4: assert property (@(posedge clk) disable iff (!rst_n)
    term_valid |-> mem_valid);

  assert_chain_fetch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (term_valid && term_chained) |-> rd_req);

  assert_disarm_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (term_valid && !term_chained) |-> (term_word == '0));

  assert_ignore_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && req_ready && (term_word == '0)) |=> !mem_valid);

  assert_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> !req_ready);

  assert_rd_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);

endmodule

bind cbt_addr_ctrl cbt_addr_ctrl_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .xfer_req     (xfer_req),
  .req_ready    (req_ready),
  .mem_valid    (mem_valid),
  .mem_addr     (mem_addr),
  .term_valid   (term_valid),
  .term_chained (term_chained),
  .rd_req       (rd_req),
  .term_word    (term_q),
  .cur_addr     (cur_q)
);

// File: tb/cbt_addr_ctrl_tb_top.sv
`timescale 1ns/1ps
module cbt_addr_ctrl_tb_top;

  localparam int AW     = 8;
  localparam int WW     = AW + 3;
  localparam int DEPTH  = 1 << AW;
  localparam int RD_LAT = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          arm_valid;
  logic [AW-1:0] arm_ptr;
  logic          xfer_req;
  logic          req_ready;
  logic          mem_valid;
  logic [AW-1:0] mem_addr;
  logic          mem_half;
  logic          term_valid;
  logic          term_chained;
  logic [AW-1:0] term_addr;
  logic          rd_req;
  logic [AW-1:0] rd_addr;
  logic          rd_valid;
  logic [WW-1:0] rd_data;

  cbt_addr_ctrl #(.ADDR_W(AW)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .arm_valid    (arm_valid),
    .arm_ptr      (arm_ptr),
    .xfer_req     (xfer_req),
    .req_ready    (req_ready),
    .mem_valid    (mem_valid),
    .mem_addr     (mem_addr),
    .mem_half     (mem_half),
    .term_valid   (term_valid),
    .term_chained (term_chained),
    .term_addr    (term_addr),
    .rd_req       (rd_req),
    .rd_addr      (rd_addr),
    .rd_valid     (rd_valid),
    .rd_data      (rd_data)
  );

  always #2 clk = ~clk;

  int errors = 0;
  int checks = 0;
  int mem_seen = 0;
  int term_seen = 0;
  int rd_seen = 0;
  bit live = 1'b0;

  logic [WW-1:0] mem [DEPTH];
  logic [AW:0]   exp_mem  [$];
  logic [AW:0]   exp_term [$];
  logic [AW-1:0] exp_rd   [$];

  // Reference model state
  logic [WW-1:0] m_term;
  logic [AW-1:0] m_cur;

  function automatic logic [WW-1:0] mk_term(bit c, bit h, bit g, logic [AW-1:0] a);
    return {c, h, g, a};
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic model_load(logic [AW-1:0] base);
    logic [AW-1:0] b1;
    b1 = base + AW'(1);
    exp_rd.push_back(base);
    exp_rd.push_back(b1);
    m_term = mem[base];
    m_cur  = mem[b1][AW-1:0];
  endtask

  // Predict outputs of one accepted request (R2..R6).
  task automatic model_xfer(output bit chained);
    chained = 1'b0;
    if (m_term != '0) begin
      exp_mem.push_back({m_term[AW+1], m_cur});
      if (m_cur == m_term[AW-1:0]) begin
        exp_term.push_back({m_term[AW+2], m_term[AW-1:0]});
        if (m_term[AW+2]) begin
          chained = 1'b1;
          model_load(m_term[AW-1:0] + AW'(1));
        end else begin
          m_term = '0;
        end
      end else begin
        m_cur = m_term[AW] ? m_cur - AW'(1) : m_cur + AW'(1);
      end
    end
  endtask

  // Driver: called at a falling edge, returns at a falling edge.
  task automatic do_xfer();
    bit ch;
    xfer_req = 1'b1;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    model_xfer(ch);
    @(negedge clk);
    xfer_req = 1'b0;
    if (ch) check(req_ready == 1'b0, "R7", "ready during chain fetch", int'(req_ready), 0);
  endtask

  task automatic ignored_xfer();
    int m0, t0, r0;
    m0 = mem_seen; t0 = term_seen; r0 = rd_seen;
    do_xfer();
    repeat (3) @(negedge clk);
    check(mem_seen == m0, "R6", "transfers on disarmed line", mem_seen - m0, 0);
    check(term_seen == t0, "R6", "end events on disarmed line", term_seen - t0, 0);
    check(rd_seen == r0, "R6", "reads on disarmed line", rd_seen - r0, 0);
  endtask

  task automatic arm(logic [AW-1:0] p);
    arm_valid = 1'b1;
    arm_ptr   = p;
    model_load(p);
    #1;
    check(req_ready == 1'b0, "R8", "ready while arming", int'(req_ready), 0);
    @(negedge clk);
    arm_valid = 1'b0;
    while (!req_ready) @(negedge clk);
  endtask

  // Monitor: scoreboard compare
  initial begin
    forever begin
      @(negedge clk);
      if (live && mem_valid) begin
        mem_seen++;
        if (exp_mem.size() == 0) begin
          check(1'b0, "R2", "unexpected transfer", int'(mem_addr), 0);
        end else begin
          logic [AW:0] e;
          e = exp_mem.pop_front();
          check({mem_half, mem_addr} == e, "R2", "half/address", int'({mem_half, mem_addr}), int'(e));
        end
      end
      if (live && term_valid) begin
        term_seen++;
        check(mem_valid == 1'b1, "R4", "end event without transfer", int'(mem_valid), 1);
        if (exp_term.size() == 0) begin
          check(1'b0, "R4", "unexpected end event", int'(term_addr), 0);
        end else begin
          logic [AW:0] e;
          e = exp_term.pop_front();
          check({term_chained, term_addr} == e, "R4", "chained/terminal", int'({term_chained, term_addr}), int'(e));
        end
      end
    end
  end

  // Descriptor memory responder
  initial begin
    rd_valid = 1'b0;
    rd_data  = '0;
    forever begin
      @(negedge clk);
      rd_valid = 1'b0;
      if (live && rd_req) begin
        logic [AW-1:0] a;
        a = rd_addr;
        rd_seen++;
        if (exp_rd.size() == 0) begin
          check(1'b0, "R9", "unexpected read", int'(a), 0);
        end else begin
          logic [AW-1:0] e;
          e = exp_rd.pop_front();
          check(a == e, "R9", "read address", int'(a), int'(e));
        end
        repeat (RD_LAT) @(negedge clk);
        rd_valid = 1'b1;
        rd_data  = mem[a];
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=done");
    report();
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
    mem[8'h10] = mk_term(1, 0, 0, 8'h22); mem[8'h11] = 11'h020;
    mem[8'h23] = mk_term(1, 1, 1, 8'h30); mem[8'h24] = 11'h032;
    mem[8'h31] = mk_term(1, 0, 0, 8'h01); mem[8'h32] = 11'h0FE;
    mem[8'h02] = mk_term(1, 0, 1, 8'hFE); mem[8'h03] = 11'h001;
    mem[8'hFF] = mk_term(0, 1, 0, 8'h41); mem[8'h00] = 11'h040;
    mem[8'h50] = mk_term(0, 0, 0, 8'h60); mem[8'h51] = 11'h060;
    m_term = '0;
    m_cur  = '0;

    rst_n     = 1'b0;
    arm_valid = 1'b0;
    arm_ptr   = '0;
    xfer_req  = 1'b0;
    repeat (3) @(negedge clk);
    check(mem_valid == 1'b0, "R1", "mem_valid in reset", int'(mem_valid), 0);
    check(term_valid == 1'b0, "R1", "term_valid in reset", int'(term_valid), 0);
    check(rd_req == 1'b0, "R1", "rd_req in reset", int'(rd_req), 0);
    check(req_ready == 1'b1, "R1", "req_ready in reset", int'(req_ready), 1);
    rst_n = 1'b1;
    live  = 1'b1;
    repeat (3) @(negedge clk);

    // R1: disarmed from reset, so the request is dropped.
    ignored_xfer();

    // R8/R5/R3: chain A -> B -> C -> D -> E, with wrap both ways.
    arm(8'h10);
    for (int n = 0; n < 16; n++) do_xfer();
    repeat (12) @(negedge clk);
    // R6: end of chain without chaining disarms the line.
    ignored_xfer();

    // Single-word buffer that ends at once.
    arm(8'h50);
    do_xfer();
    ignored_xfer();

    // R8: re-arming replaces a live buffer.
    arm(8'h10);
    do_xfer();
    do_xfer();
    arm(8'h50);
    do_xfer();
    ignored_xfer();

    repeat (10) @(negedge clk);
    check(exp_mem.size() == 0, "R7", "transfers left unserved", exp_mem.size(), 0);
    check(exp_term.size() == 0, "R4", "end events missing", exp_term.size(), 0);
    check(exp_rd.size() == 0, "R5", "reads missing", exp_rd.size(), 0);
    check(mem_seen == 20, "R2", "total transfers", mem_seen, 20);
    check(term_seen == 7, "R4", "total end events", term_seen, 7);
    report();
    $finish;
  end

endmodule